// File: doc/BRIEF.md
# SPI Register-Access Transaction Engine

This block is the host side of a serial link to a security-module target. It carries out one register access per request: a read or a write of 1 to 128 bytes at a 16-bit register address. Each access opens with a fixed four-byte command header. A polled wait state follows, and the target signals through bit 0 of its reply when it is ready. The data phase comes last. Chip select stays low for the whole exchange.

A request is a one-cycle pulse on `req` while the engine is idle. At that pulse the engine captures the direction, address, length and write data. `busy` stays high until `done` pulses. In the cycle of `done`, `err` gives the outcome and `rdata` holds the bytes read. The bus runs in SPI mode 0, MSB first, and its bit rate is set by a clock-divider parameter.

Top module: `spi_reg_xact`

## Requirements
- R1: Header byte 0 carries bit 7 = 1 for a read and 0 for a write. Its bits 6:0 hold the length minus one.
- R2: Header bytes 1 to 3 are 0xD4, then the address high byte, then the address low byte. Every byte goes out MSB first in SPI mode 0: MOSI changes on the falling clock edge and MISO is sampled on the rising edge.
- R3: A length of 0, or a length above 128, finishes with `err` = 1. Chip select never goes low and SCLK never toggles.
- R4: `hdr_reply` holds the four bytes received during the header exchange. The first byte is in bits 31:24 and the fourth in bits 7:0.
- R5: If bit 0 of the fourth received header byte is 1, the data phase follows directly. In that case exactly 4 + length bytes are exchanged.
- R6: Otherwise the engine sends 0x00 poll bytes and stops polling at the first returned byte with bit 0 = 1. The exchange then totals 4 + polls + length bytes.
- R7: After 50 polls with bit 0 = 0, the transaction ends with `err` = 2, after exactly 54 bytes. If ready arrives on the 50th poll, the data phase still runs and the access succeeds.
- R8: In a write, data byte i is taken from `req_wdata[8i+7:8i]` and sent in increasing i. MISO is ignored, and `rdata` keeps its earlier contents.
- R9: In a read, the engine sends 0x00 bytes and stores received byte i in `rdata[8i+7:8i]`.
- R10: SCLK is low whenever chip select is high. Chip select is high again in the cycle `done` pulses, for every outcome.
- R11: `err` is 0 when the access succeeds. `err` is valid in the cycle `done` pulses.
- R12: `busy` rises in the cycle after an accepted request and falls in the cycle `done` pulses. A request that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, accepted only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address |
| req_len | input | LEN_W (8) | Transfer length in bytes |
| req_wdata | input | MAX_LEN*8 (1024) | Write data, byte i in bits 8i+7:8i |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 2 | 0 success, 1 invalid length, 2 timeout |
| rdata | output | MAX_LEN*8 (1024) | Read data, byte i in bits 8i+7:8i |
| hdr_reply | output | 32 | Bytes received during the header |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest situation to reach is the edge of the poll budget. Reaching it needs a target that withholds ready for exactly 49 or 50 polls and then behaves differently in each case. Another hard case is a second request that arrives while a long access is under way. The bench's behavioural target serves every transaction from a per-transaction queue of reply bytes. The queue fixes exactly which poll first shows bit 0 set, so both the timeout and the ready-on-the-last-poll case arise from the same stimulus shape. During one access the bench also pulses a conflicting request. It then confirms that the header and data on MOSI still match the original request.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_POLL,
    ST_DATA,
    ST_FIN
  } xact_st_t;

  localparam logic [1:0] ERR_OK    = 2'd0;
  localparam logic [1:0] ERR_PARAM = 2'd1;
  localparam logic [1:0] ERR_TMO   = 2'd2;

  localparam logic [7:0] HDR_TAG   = 8'hD4;
  localparam logic [7:0] FILL_BYTE = 8'h00;
endpackage

// File: rtl/spi_xact_shifter.sv
module spi_xact_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       active,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       tx_sr;
  logic [7:0]       rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      bit_idx   <= '0;
      tx_sr     <= '0;
      rx_sr     <= '0;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      active    <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (start) begin
        active  <= 1'b1;
        sclk    <= 1'b0;
        cnt     <= '0;
        bit_idx <= '0;
        tx_sr   <= tx_byte;
        mosi    <= tx_byte[7];
      end else if (active) begin
        if (cnt == CNT_TOP) begin
          cnt <= '0;
          if (!sclk) begin
            sclk  <= 1'b1;
            rx_sr <= {rx_sr[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_idx == 3'd7) begin
              active    <= 1'b0;
              byte_done <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 3'd1;
              tx_sr   <= {tx_sr[6:0], 1'b0};
              mosi    <= tx_sr[6];
            end
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign rx_byte = rx_sr;

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !active);

  // R10
  sclk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> !sclk);
endmodule

// File: rtl/spi_xact_rxbuf.sv
module spi_xact_rxbuf #(
  parameter int MAX_LEN = 128,
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [IDX_W-1:0]     idx,
  input  logic [7:0]           wbyte,
  output logic [MAX_LEN*8-1:0] rdata
);
  logic [7:0] mem [MAX_LEN];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wbyte;
  end

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_flat
    assign rdata[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/spi_xact_ctrl.sv
module spi_xact_ctrl
  import spi_xact_pkg::*;
#(
  parameter int MAX_LEN   = 128,
  parameter int MAX_POLLS = 50,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int IDX_W    = $clog2(MAX_LEN),
  localparam int POLL_W   = $clog2(MAX_POLLS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic                 req_write,
  input  logic [15:0]          req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [MAX_LEN*8-1:0] req_wdata,
  input  logic                 byte_done,
  input  logic [7:0]           rx_byte,
  input  logic                 sh_active,
  output logic                 start,
  output logic [7:0]           tx_byte,
  output logic                 cs_n,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           err,
  output logic [31:0]          hdr_reply,
  output logic                 rx_we,
  output logic [IDX_W-1:0]     rx_idx,
  output logic [7:0]           rx_data
);
  xact_st_t             st;
  logic                 wr_q;
  logic [15:0]          addr_q;
  logic [LEN_W-1:0]     len_q;
  logic [MAX_LEN*8-1:0] wdata_q;
  logic [IDX_W-1:0]     idx;
  logic [POLL_W-1:0]    poll_cnt;
  logic [IDX_W-1:0]     last_idx;
  logic                 len_bad;

  assign last_idx = IDX_W'(len_q - LEN_W'(1));
  assign len_bad  = (req_len == '0) || (req_len > LEN_W'(MAX_LEN));

  always_comb begin
    tx_byte = FILL_BYTE;
    case (st)
      ST_HDR: begin
        case (idx[1:0])
          2'd0:    tx_byte = {~wr_q, 7'(len_q - LEN_W'(1))};
          2'd1:    tx_byte = HDR_TAG;
          2'd2:    tx_byte = addr_q[15:8];
          default: tx_byte = addr_q[7:0];
        endcase
      end
      ST_DATA: tx_byte = wr_q ? wdata_q[{idx, 3'b000} +: 8] : FILL_BYTE;
      default: tx_byte = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      len_q     <= '0;
      wdata_q   <= '0;
      idx       <= '0;
      poll_cnt  <= '0;
      start     <= 1'b0;
      cs_n      <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= ERR_OK;
      hdr_reply <= '0;
      rx_we     <= 1'b0;
      rx_idx    <= '0;
      rx_data   <= '0;
    end else begin
      start <= 1'b0;
      done  <= 1'b0;
      rx_we <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req) begin
            busy     <= 1'b1;
            wr_q     <= req_write;
            addr_q   <= req_addr;
            len_q    <= req_len;
            wdata_q  <= req_wdata;
            idx      <= '0;
            poll_cnt <= '0;
            if (len_bad) begin
              err <= ERR_PARAM;
              st  <= ST_FIN;
            end else begin
              err       <= ERR_OK;
              hdr_reply <= '0;
              cs_n      <= 1'b0;
              start     <= 1'b1;
              st        <= ST_HDR;
            end
          end
        end
        ST_HDR: begin
          if (byte_done) begin
            hdr_reply <= {hdr_reply[23:0], rx_byte};
            start     <= 1'b1;
            if (idx == IDX_W'(3)) begin
              idx <= '0;
              if (rx_byte[0]) begin
                st <= ST_DATA;
              end else begin
                st       <= ST_POLL;
                poll_cnt <= POLL_W'(1);
              end
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        ST_POLL: begin
          if (byte_done) begin
            if (rx_byte[0]) begin
              st    <= ST_DATA;
              start <= 1'b1;
            end else if (poll_cnt == POLL_W'(MAX_POLLS)) begin
              err <= ERR_TMO;
              st  <= ST_FIN;
            end else begin
              poll_cnt <= poll_cnt + POLL_W'(1);
              start    <= 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (byte_done) begin
            rx_we   <= ~wr_q;
            rx_idx  <= idx;
            rx_data <= rx_byte;
            if (idx == last_idx) begin
              st <= ST_FIN;
            end else begin
              idx   <= idx + IDX_W'(1);
              start <= 1'b1;
            end
          end
        end
        ST_FIN: begin
          cs_n <= 1'b1;
          busy <= 1'b0;
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
    poll_cnt <= POLL_W'(MAX_POLLS));

  // R10
  cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sh_active |-> !cs_n);
endmodule

// File: rtl/spi_reg_xact.sv
module spi_reg_xact
  import spi_xact_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int MAX_LEN   = 128,
  parameter int MAX_POLLS = 50,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int IDX_W    = $clog2(MAX_LEN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic                 req_write,
  input  logic [15:0]          req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [MAX_LEN*8-1:0] req_wdata,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           err,
  output logic [MAX_LEN*8-1:0] rdata,
  output logic [31:0]          hdr_reply,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic                 cs_n
);
  logic             sh_start;
  logic [7:0]       sh_tx;
  logic             sh_active;
  logic             sh_done;
  logic [7:0]       sh_rx;
  logic             rx_we;
  logic [IDX_W-1:0] rx_idx;
  logic [7:0]       rx_data;

  spi_xact_ctrl #(
    .MAX_LEN  (MAX_LEN),
    .MAX_POLLS(MAX_POLLS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_len  (req_len),
    .req_wdata(req_wdata),
    .byte_done(sh_done),
    .rx_byte  (sh_rx),
    .sh_active(sh_active),
    .start    (sh_start),
    .tx_byte  (sh_tx),
    .cs_n     (cs_n),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .hdr_reply(hdr_reply),
    .rx_we    (rx_we),
    .rx_idx   (rx_idx),
    .rx_data  (rx_data)
  );

  spi_xact_shifter #(
    .CLK_DIV(CLK_DIV)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .start    (sh_start),
    .tx_byte  (sh_tx),
    .miso     (miso),
    .sclk     (sclk),
    .mosi     (mosi),
    .active   (sh_active),
    .byte_done(sh_done),
    .rx_byte  (sh_rx)
  );

  spi_xact_rxbuf #(
    .MAX_LEN(MAX_LEN)
  ) u_rxbuf (
    .clk  (clk),
    .we   (rx_we),
    .idx  (rx_idx),
    .wbyte(rx_data),
    .rdata(rdata)
  );

  // R10
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> cs_n);

  // R12
  busy_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !busy && !done) |=> busy);

  // R3
  param_nocs_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err == ERR_PARAM) |-> $past(cs_n));
endmodule

// File: tb/test_spi_reg_xact.sv
`timescale 1ns/1ps
module test_spi_reg_xact;
  localparam int MAX_LEN = 128;
  localparam int NPOLL   = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic [MAX_LEN*8-1:0] req_wdata = '0;
  logic busy, done, sclk, mosi, cs_n;
  logic miso = 1'b0;
  logic [1:0] err;
  logic [MAX_LEN*8-1:0] rdata;
  logic [31:0] hdr_reply;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  spi_reg_xact i_spi_reg_xact (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .hdr_reply(hdr_reply), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural target
  logic [7:0] miso_q[$];
  logic [7:0] mosi_q[$];
  logic [7:0] cur_tx = '0;
  logic [7:0] cur_rx = '0;
  int tbit = 0;
  int rbit = 0;
  bit cs_fell = 0;

  function automatic logic [7:0] next_reply();
    if (miso_q.size() > 0) return miso_q.pop_front();
    return 8'h00;
  endfunction

  always @(negedge cs_n) begin
    cs_fell = 1;
    tbit = 0;
    rbit = 0;
    cur_tx = next_reply();
    miso = cur_tx[7];
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      cur_rx = {cur_rx[6:0], mosi};
      rbit++;
      if (rbit == 8) begin
        mosi_q.push_back(cur_rx);
        rbit = 0;
      end
    end
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      tbit++;
      if (tbit == 8) begin
        tbit = 0;
        cur_tx = next_reply();
      end
      miso = cur_tx[7-tbit];
    end
  end

  // per-clock reference for busy and the idle bus
  bit accepted = 0;
  bit exp_busy = 0;
  always @(posedge clk) accepted = !rst && req && !busy;

  always @(negedge clk) begin
    if (rst) begin
      exp_busy = 0;
    end else begin
      if (accepted) exp_busy = 1;
      chk(busy === (exp_busy && !done), "R12 busy", 64'(busy), 64'(exp_busy && !done));
      chk(!(cs_n && sclk), "R10 sclk idle", 64'(sclk), 64'd0);
      if (done) exp_busy = 0;
    end
  end

  function automatic logic [7:0] rd_byte(input logic [7:0] seed, input int i);
    return 8'(seed * 7 + i * 13);
  endfunction

  function automatic logic [7:0] wr_byte(input logic [7:0] seed, input int i);
    return 8'(seed ^ 8'(i * 5));
  endfunction

  // nwait: number of polls; ready: the last poll (or header if nwait==0) shows bit0=1
  task automatic xact(input bit wr, input logic [15:0] addr, input int len,
                      input int nwait, input bit ready, input logic [7:0] seed,
                      input bit inject);
    logic [7:0] exp_q[$];
    logic [7:0] hb[4];
    logic [MAX_LEN*8-1:0] prev_rd;
    bit invalid;
    bit tmo;
    int cyc;
    logic [1:0] exp_err;
    invalid = (len == 0) || (len > MAX_LEN);
    tmo = !ready && (nwait == NPOLL);
    exp_err = invalid ? 2'd1 : (tmo ? 2'd2 : 2'd0);
    miso_q.delete();
    mosi_q.delete();
    cs_fell = 0;
    prev_rd = rdata;
    hb[0] = seed;
    hb[1] = seed ^ 8'h3C;
    hb[2] = 8'(seed + 1);
    hb[3] = {seed[6:0], (nwait == 0)};
    if (!invalid) begin
      for (int i = 0; i < 4; i++) miso_q.push_back(hb[i]);
      for (int p = 1; p <= nwait; p++)
        miso_q.push_back((p == nwait && ready) ? 8'h81 : 8'(8'h40 + 2 * p));
      for (int i = 0; i < len; i++)
        miso_q.push_back(wr ? (8'hC3 ^ 8'(i)) : rd_byte(seed, i));
      exp_q.push_back({~wr, 7'(len - 1)});
      exp_q.push_back(8'hD4);
      exp_q.push_back(addr[15:8]);
      exp_q.push_back(addr[7:0]);
      for (int p = 0; p < nwait; p++) exp_q.push_back(8'h00);
      if (!tmo)
        for (int i = 0; i < len; i++) exp_q.push_back(wr ? wr_byte(seed, i) : 8'h00);
    end
    @(negedge clk);
    req_write = wr;
    req_addr  = addr;
    req_len   = 8'(len);
    for (int i = 0; i < MAX_LEN; i++) req_wdata[i*8 +: 8] = wr_byte(seed, i);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (inject) begin
      repeat (60) @(negedge clk);
      req_write = ~wr;
      req_addr  = ~addr;
      req_len   = 8'd3;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done === 1'b1, "R12 done seen", 64'(done), 64'd1);
    chk(err === exp_err, invalid ? "R3 err" : (tmo ? "R7 err" : "R11 err"),
        64'(err), 64'(exp_err));
    chk(cs_n === 1'b1, "R10 cs released at done", 64'(cs_n), 64'd1);
    if (invalid) begin
      chk(!cs_fell && mosi_q.size() == 0, "R3 no bus activity",
          64'(mosi_q.size()), 64'd0);
    end else begin
      chk(hdr_reply === {hb[0], hb[1], hb[2], hb[3]}, "R4 header reply",
          64'(hdr_reply), 64'({hb[0], hb[1], hb[2], hb[3]}));
      chk(mosi_q.size() == exp_q.size(),
          tmo ? "R7 byte count" : (nwait == 0 ? "R5 byte count" : "R6 byte count"),
          64'(mosi_q.size()), 64'(exp_q.size()));
      if (mosi_q.size() == exp_q.size()) begin
        chk(mosi_q[0] === exp_q[0], "R1 header byte0", 64'(mosi_q[0]), 64'(exp_q[0]));
        for (int i = 1; i < 4; i++)
          chk(mosi_q[i] === exp_q[i], "R2 header byte", 64'(mosi_q[i]), 64'(exp_q[i]));
        for (int i = 4; i < 4 + nwait; i++)
          chk(mosi_q[i] === 8'h00, "R6 poll byte", 64'(mosi_q[i]), 64'd0);
        for (int i = 4 + nwait; i < exp_q.size(); i++)
          chk(mosi_q[i] === exp_q[i], wr ? "R8 write byte" : "R9 read filler",
              64'(mosi_q[i]), 64'(exp_q[i]));
      end
      if (!tmo && !wr)
        for (int i = 0; i < len; i++)
          chk(rdata[i*8 +: 8] === rd_byte(seed, i), "R9 read data",
              64'(rdata[i*8 +: 8]), 64'(rd_byte(seed, i)));
      if (wr)
        chk(rdata === prev_rd, "R8 rdata untouched", 64'(rdata[63:0]), 64'(prev_rd[63:0]));
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R10 reset bus idle", 64'({cs_n, sclk}), 64'b10);
    chk(busy === 1'b0 && done === 1'b0, "R12 reset idle", 64'({busy, done}), 64'b00);
    chk(err === 2'd0, "R11 reset err", 64'(err), 64'd0);
    xact(1'b1, 16'h0F00, 1,   0,  1'b1, 8'h21, 1'b0);
    xact(1'b0, 16'h0024, 4,   3,  1'b1, 8'h42, 1'b0);
    xact(1'b0, 16'h0F80, 128, 1,  1'b1, 8'h63, 1'b0);
    xact(1'b1, 16'hA55A, 2,   2,  1'b1, 8'h84, 1'b0);
    xact(1'b0, 16'h0030, 4,   50, 1'b0, 8'h15, 1'b0);
    xact(1'b1, 16'h1234, 3,   50, 1'b1, 8'h37, 1'b0);
    xact(1'b0, 16'h0018, 129, 0,  1'b1, 8'h55, 1'b0);
    xact(1'b1, 16'h0018, 0,   0,  1'b1, 8'h56, 1'b0);
    xact(1'b0, 16'h00F0, 2,   0,  1'b1, 8'h99, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule